// File: doc/BRIEF.md
# Tagged Two-Bit Branch Prediction Buffer

This block predicts the direction of conditional branches at fetch time. It is a direct-mapped table. Each slot holds a valid flag, an address tag and a two-bit saturating confidence counter. The fetch stage presents an instruction address on the lookup port. The block answers in the same cycle whether the address is known, and if it is, whether the branch is expected to be taken.

When a branch resolves, its address and real outcome are presented on the update port. If the slot does not hold that branch, the slot is claimed for it with a weak counter that points at the observed direction. If the slot already holds the branch, the counter moves one step towards the outcome. Because the counter saturates, a branch sitting in a strong state needs two wrong guesses in a row before its prediction changes. This keeps loop branches stable across the single exit of a nested loop.

Computing the branch target and flushing the pipeline are handled outside this block.

Top module: `bp_tagged_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every slot, so every lookup misses from the first cycle after the reset edge.
- R2: A lookup that misses drives lk_hit=0 and lk_taken=0; the default prediction is not taken.
- R3: The slot index is address bits 11:2 and the tag is bits 31:12. Addresses that differ only in bits 1:0 share a slot. An address with the same index but a different tag misses, and an update from it replaces the slot's previous owner.
- R4: A lookup that hits drives lk_hit=1 and lk_taken equal to the upper bit of the slot's counter. Codes 2'b10 and 2'b11 predict taken; 2'b00 and 2'b01 predict not taken.
- R5: An update that misses writes the new tag, sets the valid flag and sets the counter to 2'b10 for a taken outcome or 2'b01 for a not-taken outcome.
- R6: An update that hits with a taken outcome increments the counter, saturating at 2'b11.
- R7: An update that hits with a not-taken outcome decrements the counter, saturating at 2'b00.
- R8: From a strong state (2'b11 or 2'b00), one opposite outcome leaves the prediction unchanged and a second consecutive opposite outcome flips it.
- R9: An update takes effect at the next rising clock edge; a lookup of the same address in the update's own cycle sees the state before the update.
- R10: Reset has priority over an update presented in the same cycle; that update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Fetch address to predict |
| lk_hit | output | 1 | Lookup address is held in the table |
| lk_taken | output | 1 | Predicted taken |
| up_en | input | 1 | Resolved-branch update strobe |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bound checker watches the ports on every cycle. It checks that a miss never predicts taken, that the table reads empty right after a reset, and that an updated address hits on the following cycle. It also checks that an update agreeing with the current prediction never reverses it. The exact counter codes need the bench's reference model and its scenarios. So do the allocation direction and saturation, the strong-state hysteresis over a nested-loop trace, tag conflicts between addresses that share an index, and reset priority over a simultaneous update.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'b10;
  localparam ctr_t CTR_WEAK_NOT   = 2'b01;

  // Saturating one-step move towards the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic ctr_t ctr_alloc(input logic taken);
    return taken ? CTR_WEAK_TAKEN : CTR_WEAK_NOT;
  endfunction
endpackage

// File: rtl/bp_addr_split.sv
module bp_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  logic unused_lo;
  assign unused_lo = ^addr[1:0];
  assign idx = addr[IDX_W+1:2];
  assign tag = addr[ADDR_W-1:IDX_W+2];
endmodule

// File: rtl/bp_valid_bits.sv
module bp_valid_bits #(
  parameter int DEPTH = 1024,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic             rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_b
);
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst)         vld <= '0;
    else if (set_en) vld[set_idx] <= 1'b1;
  end

  assign rd_a = vld[rd_a_idx];
  assign rd_b = vld[rd_b_idx];
endmodule

// File: rtl/bp_entry_ram.sv
module bp_entry_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 22,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ra_addr,
  output logic [W-1:0]     ra_data,
  input  logic [IDX_W-1:0] rb_addr,
  output logic [W-1:0]     rb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/bp_tagged_predictor.sv
module bp_tagged_predictor #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  import bp_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam int ENT_W = TAG_W + 2;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             lk_vld, up_vld;
  logic [ENT_W-1:0] lk_ent, up_ent, wr_ent;
  logic             up_hit, wr_en;
  ctr_t             up_ctr_nxt;

  bp_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) lk_split_i (
    .addr(lk_addr), .idx(lk_idx), .tag(lk_tag));

  bp_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) up_split_i (
    .addr(up_addr), .idx(up_idx), .tag(up_tag));

  assign wr_en = up_en && !rst;

  bp_valid_bits #(.DEPTH(ENTRIES), .IDX_W(IDX_W)) vld_i (
    .clk(clk), .rst(rst), .set_en(wr_en), .set_idx(up_idx),
    .rd_a_idx(lk_idx), .rd_a(lk_vld), .rd_b_idx(up_idx), .rd_b(up_vld));

  bp_entry_ram #(.DEPTH(ENTRIES), .W(ENT_W), .IDX_W(IDX_W)) ram_i (
    .clk(clk), .we(wr_en), .waddr(up_idx), .wdata(wr_ent),
    .ra_addr(lk_idx), .ra_data(lk_ent), .rb_addr(up_idx), .rb_data(up_ent));

  // Update side: allocate on miss, otherwise step the stored counter.
  always_comb begin
    up_hit = up_vld && (up_ent[ENT_W-1:2] == up_tag);
    if (up_hit) up_ctr_nxt = ctr_step(up_ent[1:0], up_taken);
    else        up_ctr_nxt = ctr_alloc(up_taken);
    wr_ent = {up_tag, up_ctr_nxt};
  end

  // Lookup side: prediction comes from the counter's upper bit on a hit.
  always_comb begin
    lk_hit   = lk_vld && (lk_ent[ENT_W-1:2] == lk_tag);
    lk_taken = lk_hit && lk_ent[1];
  end
endmodule

// File: rtl/bp_tagged_predictor_chk.sv
module bp_tagged_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic              up_en,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_taken
);
  AST_MISS_PREDICTS_NT: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_taken); // R2

  AST_RESET_EMPTIES: assert property (@(posedge clk)
    $past(rst) |-> !lk_hit); // R1

  AST_UPDATE_MAKES_HIT: assert property (@(posedge clk) disable iff (rst)
    up_en |=> ((lk_addr != $past(up_addr)) || lk_hit)); // R5

  AST_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (up_en && up_taken && (lk_addr == up_addr) && lk_taken)
    |=> ((lk_addr != $past(up_addr)) || lk_taken)); // R6

  AST_NOT_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (up_en && !up_taken && (lk_addr == up_addr) && !lk_taken)
    |=> ((lk_addr != $past(up_addr)) || !lk_taken)); // R7
endmodule

bind bp_tagged_predictor bp_tagged_predictor_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
  .up_en(up_en), .up_addr(up_addr), .up_taken(up_taken));

// File: tb/bp_tagged_predictor_tb.sv
module bp_tagged_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_taken;
  logic        up_en = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_taken = 1'b0;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic        m_vld [1024];
  logic [19:0] m_tag [1024];
  logic [1:0]  m_ctr [1024];

  always #10 clk = ~clk; // 50 MHz

  bp_tagged_predictor dut_i (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .up_en(up_en), .up_addr(up_addr), .up_taken(up_taken));

  function automatic logic [1:0] m_look(input logic [31:0] a);
    logic h;
    h = m_vld[a[11:2]] && (m_tag[a[11:2]] == a[31:12]);
    return {h, h && m_ctr[a[11:2]][1]};
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 1024; i++) m_vld[i] = 1'b0;
  endtask

  task automatic m_update(input logic [31:0] a, input logic t);
    int i;
    i = int'(a[11:2]);
    if (m_vld[i] && m_tag[i] == a[31:12]) begin
      if (t && m_ctr[i] != 2'b11) m_ctr[i] = m_ctr[i] + 2'd1;
      else if (!t && m_ctr[i] != 2'b00) m_ctr[i] = m_ctr[i] - 2'd1;
    end else begin
      m_vld[i] = 1'b1;
      m_tag[i] = a[31:12];
      m_ctr[i] = t ? 2'b10 : 2'b01;
    end
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hit,taken} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Present lookup and update for one cycle; check lookup against model before the edge.
  task automatic step(input logic [31:0] la, input logic ue, input logic [31:0] ua,
                      input logic ut, input string req);
    @(negedge clk);
    lk_addr = la; up_en = ue; up_addr = ua; up_taken = ut;
    #5;
    check(req, {lk_hit, lk_taken}, m_look(la));
    if (ue) m_update(ua, ut);
  endtask

  task automatic look(input logic [31:0] la, input string req);
    step(la, 1'b0, 32'h0, 1'b0, req);
  endtask

  task automatic upd(input logic [31:0] ua, input logic t, input string req);
    step(ua, 1'b1, ua, t, req);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] INNER = 32'h0040_1a3c;
  localparam logic [31:0] OUTER = 32'h0040_1a60;
  localparam logic [31:0] PA    = 32'h1234_5678;
  localparam logic [31:0] PB    = 32'h8765_0678; // same index as PA, other tag

  initial begin
    logic [31:0] ra, rl;
    void'($urandom(32'd1357));
    m_clear();
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1 / R2: empty table after reset
    look(32'h0000_0000, "R1");
    look(32'hffff_fffc, "R2");
    check("R2 literal", {lk_hit, lk_taken}, 2'b00);

    // R9 + R5: allocate taken; same-cycle lookup still sees old state
    upd(PA, 1'b1, "R9");
    look(PA, "R5");
    check("R5 weak taken", {lk_hit, lk_taken}, 2'b11);
    // R3: low bits ignored
    look(PA | 32'h3, "R3");
    // R6 + R8: saturate at strong taken, then two not-taken to flip
    upd(PA, 1'b1, "R6");
    upd(PA, 1'b1, "R6");
    upd(PA, 1'b0, "R8");
    look(PA, "R8");
    check("R8 one miss holds", {lk_hit, lk_taken}, 2'b11);
    upd(PA, 1'b0, "R8");
    look(PA, "R8");
    check("R8 two misses flip", {lk_hit, lk_taken}, 2'b10);
    // R7: saturate low, one taken keeps not-taken
    upd(PA, 1'b0, "R7");
    upd(PA, 1'b0, "R7");
    upd(PA, 1'b1, "R7");
    look(PA, "R7");
    check("R7 strong not", {lk_hit, lk_taken}, 2'b10);
    // R3: conflict with same index, different tag
    look(PB, "R3");
    upd(PB, 1'b0, "R3");
    look(PA, "R3");
    check("R3 evicted", {lk_hit, lk_taken}, 2'b00);
    look(PB, "R4");
    check("R4 weak not", {lk_hit, lk_taken}, 2'b10);

    // Nested loop replay: inner branch taken 3x then exits, outer taken
    for (int o = 0; o < 5; o++) begin
      for (int k = 0; k < 4; k++) upd(INNER, (k != 3), "R4");
      upd(OUTER, 1'b1, "R4");
    end
    look(INNER, "R8");
    check("R8 inner stays taken", {lk_hit, lk_taken}, 2'b11);

    // R10: reset with a simultaneous update
    @(negedge clk);
    rst = 1'b1; up_en = 1'b1; up_addr = OUTER; up_taken = 1'b1; lk_addr = OUTER;
    @(negedge clk);
    rst = 1'b0; up_en = 1'b0;
    m_clear();
    look(OUTER, "R10");
    check("R10 literal", {lk_hit, lk_taken}, 2'b00);
    look(INNER, "R1");

    // Constrained random traffic over a small pool to force hits and conflicts
    for (int n = 0; n < 3000; n++) begin
      ra = {12'h0a0 + 12'($urandom_range(0, 2)), 8'h00, 10'($urandom_range(0, 7)), 2'($urandom)};
      rl = ($urandom_range(0, 3) == 0) ? ra :
           {12'h0a0 + 12'($urandom_range(0, 2)), 8'h00, 10'($urandom_range(0, 7)), 2'($urandom)};
      step(rl, ($urandom_range(0, 3) != 0), ra, $urandom_range(0, 1) == 1, "R4 R6 R7 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule